// File: doc/BRIEF.md
# Variable-length instruction byte parser

This block splits a stream of 32-bit-mode machine-code bytes into instructions and reports the fields of each one. It takes one byte per cycle over a valid/ready handshake. It first consumes an optional operand-size prefix, then the opcode, the addressing byte, an optional scale/index/base byte, the displacement and the immediate. It works out from the bytes already seen how many more bytes belong to the current instruction, so it never has to look ahead.

When the last byte of an instruction has been taken, the block presents one record on its output. The record holds the opcode, the addressing-byte fields, the scale/index/base fields, the displacement sign-extended to 32 bits, the immediate, the operand width, the destination register and the total byte count. Three opcode groups are recognised: the three-operand signed multiply pair, the sixteen move-immediate-to-register opcodes, and the two-operand ALU opcodes that carry a direction bit. Any other opcode produces a one-record error, and parsing starts again at the next byte.

A downstream decode stage uses the block to learn where each instruction ends and what its operands are. It holds a record until that stage takes it. It only holds off input while a finished record is waiting and the stage is not ready for it.

Top module: `vlp_parser`

## Requirements
- R1: in_ready is high whenever out_valid is low or out_ready is high. While out_valid is high and out_ready is low, in_ready is low and every record output holds its value. Each instruction yields exactly one record.
- R2: For the addressing byte, out_mod is bits 7:6, out_reg is bits 5:3 and out_rm is bits 2:0, and out_has_modrm is 1. For the scale/index/base byte, out_scale is bits 7:6, out_index is bits 5:3 and out_base is bits 2:0.
- R3: The displacement length follows from mod and r/m. mod=11 gives none. mod=01 gives one byte, output sign-extended to 32 bits. mod=10 gives four bytes. mod=00 with r/m=101 gives four bytes and no scale/index/base byte. Any other mod=00 case gives none.
- R4: A scale/index/base byte follows the addressing byte exactly when mod is not 11 and r/m=100 (out_has_sib=1). After it, mod=00 with base=101 gives a four-byte displacement, and mod 01 or 10 keeps the lengths of R3.
- R5: Multi-byte displacements and immediates are assembled little-endian, so the first byte received becomes bits 7:0.
- R6: Opcode 0x69 carries an addressing byte and a full-width immediate (4 bytes, or 2 with the prefix), zero-extended into out_imm. Opcode 0x6B carries an addressing byte and one immediate byte, sign-extended to 32 bits. For both, out_dst is the reg field.
- R7: Opcodes 0xB0 to 0xBF carry no addressing byte, and out_dst is opcode bits 2:0. When opcode bit 3 is 0 the opcode takes one immediate byte and the width is 8. When bit 3 is 1 it takes a full-width immediate. The immediate is zero-extended.
- R8: The ALU opcodes are those with opcode bits 7:6 = 00 and bit 2 = 0. They carry an addressing byte and no immediate. Opcode bit 0 = 0 means width 8 and bit 0 = 1 means full width. Opcode bit 1 = 1 makes reg the destination. Opcode bit 1 = 0 makes r/m the destination, and out_dst_mem is then 1 when mod is not 11.
- R9: out_width encodes 0 = 8 bits, 1 = 16 bits and 2 = 32 bits. Full width is 32 unless one or more 0x66 prefix bytes came first, in which case it is 16 and a full-width immediate is 2 bytes. The prefix has no effect on 8-bit opcodes. Up to MAX_PREFIX (default 4) prefix bytes are accepted, and one more 0x66 is treated as an opcode.
- R10: An opcode outside R6 to R8 produces a record with out_err=1, the opcode, out_len = prefix count + 1, and every other field 0. The next byte starts a new instruction.
- R11: out_len equals the number of bytes in the instruction, prefixes included.
- R12: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte on in_data is offered |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte is taken on this edge when in_valid is high |
| out_valid | output | 1 | Record is presented |
| out_ready | input | 1 | Consumer takes the record |
| out_err | output | 1 | Opcode not in the supported groups |
| out_opcode | output | 8 | Opcode byte |
| out_width | output | 2 | Operand width code (0 = 8, 1 = 16, 2 = 32) |
| out_len | output | LEN_W | Instruction length in bytes |
| out_has_modrm | output | 1 | Addressing byte present |
| out_mod | output | 2 | Addressing mode field |
| out_reg | output | 3 | Register field |
| out_rm | output | 3 | Register/memory field |
| out_has_sib | output | 1 | Scale/index/base byte present |
| out_scale | output | 2 | Scale field |
| out_index | output | 3 | Index field |
| out_base | output | 3 | Base field |
| out_disp | output | 32 | Displacement, sign-extended when one byte long |
| out_imm | output | 32 | Immediate |
| out_dst | output | 3 | Destination register code |
| out_dst_mem | output | 1 | Destination is the memory operand |

## Verification
The assertions assume the consumer sees only records the parser has built, and that inputs carry known values once reset is released. Beyond that they place no limit on in_valid or out_ready, so stall and hold behaviour is checked under any handshake pattern. The stimulus offers bytes with random gaps and deasserts out_ready at random, so records are held back and the input is stalled. It also includes a stretch where both sides run every cycle, to show the parser keeps up with one byte per clock.

// File: rtl/vlp_pkg.sv
`timescale 1ns/1ps
package vlp_pkg;

    localparam logic [7:0] PFX_OSZ = 8'h66;

    localparam logic [1:0] WID_8  = 2'd0;
    localparam logic [1:0] WID_16 = 2'd1;
    localparam logic [1:0] WID_32 = 2'd2;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_MODRM,
        PH_SIB,
        PH_DISP,
        PH_IMM
    } phase_e;

    typedef enum logic [1:0] {
        OC_BAD,
        OC_MUL,
        OC_MOVI,
        OC_ALU
    } opclass_e;

    typedef struct packed {
        logic        err;
        logic [7:0]  opcode;
        logic [1:0]  width;
        logic        has_modrm;
        logic [1:0]  mod;
        logic [2:0]  reg_f;
        logic [2:0]  rm;
        logic        has_sib;
        logic [1:0]  scale;
        logic [2:0]  index;
        logic [2:0]  base;
        logic [31:0] disp;
        logic [31:0] imm;
        logic [2:0]  dst;
        logic        dst_mem;
    } rec_t;

endpackage

// File: rtl/vlp_opclass.sv
`timescale 1ns/1ps
module vlp_opclass
    import vlp_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic       osz,
    output opclass_e   cls,
    output logic [2:0] imm_len,
    output logic [1:0] width,
    output logic       imm_sext
);
    logic [1:0] full_w;
    logic [2:0] full_len;

    always_comb begin
        full_w   = osz ? WID_16 : WID_32;
        full_len = osz ? 3'd2 : 3'd4;
        cls      = OC_BAD;
        imm_len  = 3'd0;
        width    = WID_8;
        imm_sext = 1'b0;
        if ((opcode & 8'hFD) == 8'h69) begin
            cls      = OC_MUL;
            width    = full_w;
            imm_len  = opcode[1] ? 3'd1 : full_len;
            imm_sext = opcode[1];
        end else if (opcode[7:4] == 4'hB) begin
            cls     = OC_MOVI;
            width   = opcode[3] ? full_w : WID_8;
            imm_len = opcode[3] ? full_len : 3'd1;
        end else if (opcode[7:6] == 2'b00 && !opcode[2]) begin
            cls     = OC_ALU;
            width   = opcode[0] ? full_w : WID_8;
            imm_len = 3'd0;
        end
    end
endmodule

// File: rtl/vlp_disp_sizer.sv
`timescale 1ns/1ps
module vlp_disp_sizer (
    input  logic [1:0] mod,
    input  logic [2:0] low3,
    output logic [2:0] disp_len
);
    always_comb begin
        unique case (mod)
            2'b01:   disp_len = 3'd1;
            2'b10:   disp_len = 3'd4;
            2'b00:   disp_len = (low3 == 3'b101) ? 3'd4 : 3'd0;
            default: disp_len = 3'd0;
        endcase
    end
endmodule

// File: rtl/vlp_byte_lane.sv
`timescale 1ns/1ps
module vlp_byte_lane #(
    parameter int BYTES = 4,
    localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic [8*BYTES-1:0] acc,
    input  logic [7:0]         byte_in,
    input  logic [IDX_W-1:0]   idx,
    output logic [8*BYTES-1:0] merged
);
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign merged[8*g +: 8] = (idx == IDX_W'(g)) ? byte_in : acc[8*g +: 8];
    end
endmodule

// File: rtl/vlp_parser.sv
`timescale 1ns/1ps
module vlp_parser
    import vlp_pkg::*;
#(
    parameter int MAX_PREFIX = 4,
    localparam int PC_W  = $clog2(MAX_PREFIX + 1),
    localparam int LEN_W = $clog2(MAX_PREFIX + 12),
    localparam int WORD_BYTES = 4,
    localparam int IDX_W = $clog2(WORD_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_err,
    output logic [7:0]       out_opcode,
    output logic [1:0]       out_width,
    output logic [LEN_W-1:0] out_len,
    output logic             out_has_modrm,
    output logic [1:0]       out_mod,
    output logic [2:0]       out_reg,
    output logic [2:0]       out_rm,
    output logic             out_has_sib,
    output logic [1:0]       out_scale,
    output logic [2:0]       out_index,
    output logic [2:0]       out_base,
    output logic [31:0]      out_disp,
    output logic [31:0]      out_imm,
    output logic [2:0]       out_dst,
    output logic             out_dst_mem
);
    typedef struct packed {
        phase_e          phase;
        logic [PC_W-1:0] pfx_cnt;
        logic            osz;
        logic [7:0]      opcode;
        logic            has_modrm;
        logic [1:0]      mod;
        logic [2:0]      reg_f;
        logic [2:0]      rm;
        logic            has_sib;
        logic [1:0]      scale;
        logic [2:0]      index;
        logic [2:0]      base;
        logic [31:0]     disp;
        logic [2:0]      disp_len;
        logic [31:0]     imm;
        logic [IDX_W-1:0] idx;
        logic [LEN_W-1:0] len;
        rec_t            rec;
        logic [LEN_W-1:0] rec_len;
        logic            rec_valid;
    } st_t;

    st_t q, d;

    // opcode classification: the incoming byte in the opcode phase, the held one later
    logic [7:0] opc_src;
    opclass_e   cls;
    logic [2:0] imm_len;
    logic [1:0] cls_width;
    logic       imm_sext;

    assign opc_src = (q.phase == PH_OPC) ? in_data : q.opcode;

    vlp_opclass u_opclass (
        .opcode   (opc_src),
        .osz      (q.osz),
        .cls      (cls),
        .imm_len  (imm_len),
        .width    (cls_width),
        .imm_sext (imm_sext)
    );

    // displacement length from the addressing byte and from the base field
    logic [2:0] dl_modrm;
    logic [2:0] dl_sib;

    vlp_disp_sizer u_size_modrm (
        .mod      (in_data[7:6]),
        .low3     (in_data[2:0]),
        .disp_len (dl_modrm)
    );

    vlp_disp_sizer u_size_sib (
        .mod      (q.mod),
        .low3     (in_data[2:0]),
        .disp_len (dl_sib)
    );

    logic [31:0] disp_merged;
    logic [31:0] imm_merged;

    vlp_byte_lane #(.BYTES(WORD_BYTES)) u_lane_disp (
        .acc     (q.disp),
        .byte_in (in_data),
        .idx     (q.idx),
        .merged  (disp_merged)
    );

    vlp_byte_lane #(.BYTES(WORD_BYTES)) u_lane_imm (
        .acc     (q.imm),
        .byte_in (in_data),
        .idx     (q.idx),
        .merged  (imm_merged)
    );

    logic take;
    logic fin;
    logic bad;
    logic [2:0] idx_ext;

    assign in_ready = !q.rec_valid || out_ready;
    assign take     = in_valid && in_ready;
    assign idx_ext  = 3'(q.idx);

    always_comb begin
        d   = q;
        fin = 1'b0;
        bad = 1'b0;

        if (q.rec_valid && out_ready) begin
            d.rec_valid = 1'b0;
        end

        if (take) begin
            d.len = q.len + 1'b1;
            unique case (q.phase)
                PH_OPC: begin
                    if (in_data == PFX_OSZ && q.pfx_cnt < PC_W'(MAX_PREFIX)) begin
                        d.pfx_cnt = q.pfx_cnt + 1'b1;
                        d.osz     = 1'b1;
                    end else begin
                        d.opcode = in_data;
                        d.idx    = '0;
                        unique case (cls)
                            OC_BAD:  bad     = 1'b1;
                            OC_MOVI: d.phase = PH_IMM;
                            default: d.phase = PH_MODRM;
                        endcase
                    end
                end
                PH_MODRM: begin
                    d.has_modrm = 1'b1;
                    d.mod       = in_data[7:6];
                    d.reg_f     = in_data[5:3];
                    d.rm        = in_data[2:0];
                    if (in_data[7:6] != 2'b11 && in_data[2:0] == 3'b100) begin
                        d.phase = PH_SIB;
                    end else begin
                        d.disp_len = dl_modrm;
                        if (dl_modrm != 3'd0) begin
                            d.phase = PH_DISP;
                        end else if (imm_len != 3'd0) begin
                            d.phase = PH_IMM;
                        end else begin
                            fin = 1'b1;
                        end
                    end
                end
                PH_SIB: begin
                    d.has_sib  = 1'b1;
                    d.scale    = in_data[7:6];
                    d.index    = in_data[5:3];
                    d.base     = in_data[2:0];
                    d.disp_len = dl_sib;
                    if (dl_sib != 3'd0) begin
                        d.phase = PH_DISP;
                    end else if (imm_len != 3'd0) begin
                        d.phase = PH_IMM;
                    end else begin
                        fin = 1'b1;
                    end
                end
                PH_DISP: begin
                    d.disp = disp_merged;
                    d.idx  = q.idx + 1'b1;
                    if (idx_ext == q.disp_len - 3'd1) begin
                        d.idx = '0;
                        if (imm_len != 3'd0) begin
                            d.phase = PH_IMM;
                        end else begin
                            fin = 1'b1;
                        end
                    end
                end
                PH_IMM: begin
                    d.imm = imm_merged;
                    d.idx = q.idx + 1'b1;
                    if (idx_ext == imm_len - 3'd1) begin
                        fin = 1'b1;
                    end
                end
                default: d.phase = PH_OPC;
            endcase
        end

        if (fin || bad) begin
            d.rec_valid = 1'b1;
            d.rec_len   = d.len;
            d.rec       = '0;
            d.rec.opcode = d.opcode;
            if (bad) begin
                d.rec.err = 1'b1;
            end else begin
                d.rec.width     = cls_width;
                d.rec.has_modrm = d.has_modrm;
                d.rec.mod       = d.mod;
                d.rec.reg_f     = d.reg_f;
                d.rec.rm        = d.rm;
                d.rec.has_sib   = d.has_sib;
                d.rec.scale     = d.scale;
                d.rec.index     = d.index;
                d.rec.base      = d.base;
                d.rec.disp      = (d.disp_len == 3'd1) ? {{24{d.disp[7]}}, d.disp[7:0]} : d.disp;
                d.rec.imm       = imm_sext ? {{24{d.imm[7]}}, d.imm[7:0]} : d.imm;
                unique case (cls)
                    OC_MOVI: d.rec.dst = d.opcode[2:0];
                    OC_ALU:  d.rec.dst = d.opcode[1] ? d.reg_f : d.rm;
                    default: d.rec.dst = d.reg_f;
                endcase
                d.rec.dst_mem = (cls == OC_ALU) && !d.opcode[1] && (d.mod != 2'b11);
            end
            // working fields return to the idle instruction state
            d.phase     = PH_OPC;
            d.pfx_cnt   = '0;
            d.osz       = 1'b0;
            d.opcode    = '0;
            d.has_modrm = 1'b0;
            d.mod       = '0;
            d.reg_f     = '0;
            d.rm        = '0;
            d.has_sib   = 1'b0;
            d.scale     = '0;
            d.index     = '0;
            d.base      = '0;
            d.disp      = '0;
            d.disp_len  = '0;
            d.imm       = '0;
            d.idx       = '0;
            d.len       = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid     = q.rec_valid;
    assign out_err       = q.rec.err;
    assign out_opcode    = q.rec.opcode;
    assign out_width     = q.rec.width;
    assign out_len       = q.rec_len;
    assign out_has_modrm = q.rec.has_modrm;
    assign out_mod       = q.rec.mod;
    assign out_reg       = q.rec.reg_f;
    assign out_rm        = q.rec.rm;
    assign out_has_sib   = q.rec.has_sib;
    assign out_scale     = q.rec.scale;
    assign out_index     = q.rec.index;
    assign out_base      = q.rec.base;
    assign out_disp      = q.rec.disp;
    assign out_imm       = q.rec.imm;
    assign out_dst       = q.rec.dst;
    assign out_dst_mem   = q.rec.dst_mem;
endmodule

// File: rtl/vlp_checker.sv
`timescale 1ns/1ps
module vlp_checker #(
    parameter int MAX_PREFIX = 4,
    localparam int LEN_W = $clog2(MAX_PREFIX + 12)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_err,
    input logic [7:0]       out_opcode,
    input logic [1:0]       out_width,
    input logic [LEN_W-1:0] out_len,
    input logic             out_has_modrm,
    input logic [1:0]       out_mod,
    input logic [2:0]       out_rm,
    input logic             out_has_sib,
    input logic [31:0]      out_disp,
    input logic [31:0]      out_imm,
    input logic [2:0]       out_dst
);
    // R1
    ready_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R1
    ready_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R1
    record_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_opcode) && $stable(out_len)
                                       && $stable(out_disp) && $stable(out_imm)));

    // R3
    disp8_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err && out_has_modrm && out_mod == 2'b01)
        |-> (out_disp[31:8] == {24{out_disp[7]}}));

    // R4
    sib_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err)
        |-> (out_has_sib == (out_has_modrm && out_mod != 2'b11 && out_rm == 3'b100)));

    // R7
    movi_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err && out_opcode[7:4] == 4'hB)
        |-> (!out_has_modrm && out_dst == out_opcode[2:0]));

    // R9
    width_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_width != 2'd3));

    // R10
    err_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err)
        |-> (!out_has_modrm && !out_has_sib && out_disp == 32'd0 && out_imm == 32'd0));

    // R11
    len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len != '0));
endmodule

bind vlp_parser vlp_checker #(.MAX_PREFIX(MAX_PREFIX)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_err       (out_err),
    .out_opcode    (out_opcode),
    .out_width     (out_width),
    .out_len       (out_len),
    .out_has_modrm (out_has_modrm),
    .out_mod       (out_mod),
    .out_rm        (out_rm),
    .out_has_sib   (out_has_sib),
    .out_disp      (out_disp),
    .out_imm       (out_imm),
    .out_dst       (out_dst)
);

// File: tb/vlp_parser_test.sv
`timescale 1ns/1ps
module vlp_parser_test;
    localparam int MAXP  = 4;
    localparam int LEN_W = $clog2(MAXP + 12);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = 8'h00;
    logic             in_ready;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic             out_err;
    logic [7:0]       out_opcode;
    logic [1:0]       out_width;
    logic [LEN_W-1:0] out_len;
    logic             out_has_modrm;
    logic [1:0]       out_mod;
    logic [2:0]       out_reg;
    logic [2:0]       out_rm;
    logic             out_has_sib;
    logic [1:0]       out_scale;
    logic [2:0]       out_index;
    logic [2:0]       out_base;
    logic [31:0]      out_disp;
    logic [31:0]      out_imm;
    logic [2:0]       out_dst;
    logic             out_dst_mem;

    always #2.5 clk = ~clk;

    vlp_parser #(.MAX_PREFIX(MAXP)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_err(out_err), .out_opcode(out_opcode), .out_width(out_width),
        .out_len(out_len), .out_has_modrm(out_has_modrm), .out_mod(out_mod),
        .out_reg(out_reg), .out_rm(out_rm), .out_has_sib(out_has_sib),
        .out_scale(out_scale), .out_index(out_index), .out_base(out_base),
        .out_disp(out_disp), .out_imm(out_imm), .out_dst(out_dst),
        .out_dst_mem(out_dst_mem)
    );

    typedef struct {
        logic [7:0]  op;
        logic        err;
        logic [1:0]  w;
        int          len;
        logic        hm;
        logic [1:0]  mod;
        logic [2:0]  rg;
        logic [2:0]  rm;
        logic        hs;
        logic [1:0]  sc;
        logic [2:0]  ix;
        logic [2:0]  bs;
        logic [31:0] disp;
        logic [31:0] imm;
        logic [2:0]  dst;
        logic        dm;
    } exp_t;

    logic [7:0] bq[$];
    exp_t       eq[$];
    int checks = 0;
    int fails  = 0;

    task automatic cmp(input string tag, input string nm, input logic [31:0] a, input logic [31:0] e);
        checks++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, nm, a, e);
        end
    endtask

    // behavioural reference: decode one instruction given as bytes, first byte leftmost
    task automatic insn(input int n, input logic [119:0] v);
        logic [7:0] b[16];
        exp_t x;
        int i = 0;
        int p = 0;
        int osz = 0;
        int dl = 0;
        int il = 0;
        logic [1:0] fw;
        logic [7:0] op;
        for (int k = 0; k < n; k++) begin
            b[k] = v[8*(n-1-k) +: 8];
            bq.push_back(b[k]);
        end
        x = '{default: '0};
        while (i < n && b[i] == 8'h66 && p < MAXP) begin
            osz = 1; p++; i++;
        end
        op = b[i]; i++;
        x.op = op;
        fw = osz ? 2'd1 : 2'd2;
        if (op >= 8'hB0 && op <= 8'hBF) begin
            x.w   = op[3] ? fw : 2'd0;
            il    = op[3] ? (osz ? 2 : 4) : 1;
            x.dst = op[2:0];
        end else if (op == 8'h69 || op == 8'h6B || (op < 8'h40 && (op % 8) < 4)) begin
            x.hm = 1; x.mod = b[i][7:6]; x.rg = b[i][5:3]; x.rm = b[i][2:0]; i++;
            if (x.mod != 3 && x.rm == 4) begin
                x.hs = 1; x.sc = b[i][7:6]; x.ix = b[i][5:3]; x.bs = b[i][2:0]; i++;
                dl = (x.mod == 1) ? 1 : (x.mod == 2) ? 4 : (x.bs == 5) ? 4 : 0;
            end else begin
                dl = (x.mod == 1) ? 1 : (x.mod == 2) ? 4 : (x.mod == 0 && x.rm == 5) ? 4 : 0;
            end
            for (int k = 0; k < dl; k++) begin
                x.disp = x.disp | (32'(b[i]) << (8*k)); i++;
            end
            if (dl == 1 && x.disp[7]) x.disp = x.disp | 32'hFFFFFF00;
            if (op == 8'h69 || op == 8'h6B) begin
                x.w = fw; il = (op == 8'h6B) ? 1 : (osz ? 2 : 4); x.dst = x.rg;
            end else begin
                x.w = op[0] ? fw : 2'd0;
                x.dst = op[1] ? x.rg : x.rm;
                x.dm = !op[1] && x.mod != 3;
            end
        end else begin
            x.err = 1;
        end
        for (int k = 0; k < il; k++) begin
            x.imm = x.imm | (32'(b[i]) << (8*k)); i++;
        end
        if (op == 8'h6B && x.imm[7]) x.imm = x.imm | 32'hFFFFFF00;
        x.len = i;
        eq.push_back(x);
    endtask

    function automatic exp_t grab();
        exp_t g;
        g.op = out_opcode; g.err = out_err; g.w = out_width; g.len = int'(out_len);
        g.hm = out_has_modrm; g.mod = out_mod; g.rg = out_reg; g.rm = out_rm;
        g.hs = out_has_sib; g.sc = out_scale; g.ix = out_index; g.bs = out_base;
        g.disp = out_disp; g.imm = out_imm; g.dst = out_dst; g.dm = out_dst_mem;
        return g;
    endfunction

    task automatic cmp_rec(input exp_t a, input exp_t e);
        cmp("R10", "err", 32'(a.err), 32'(e.err));
        cmp("R11", "opcode", 32'(a.op), 32'(e.op));
        cmp("R11", "len", 32'(a.len), 32'(e.len));
        cmp("R9", "width", 32'(a.w), 32'(e.w));
        cmp("R2", "modrm", {a.hm, a.mod, a.rg, a.rm}, {e.hm, e.mod, e.rg, e.rm});
        cmp("R4", "sib", {a.hs, a.sc, a.ix, a.bs}, {e.hs, e.sc, e.ix, e.bs});
        cmp("R3", "disp", a.disp, e.disp);
        cmp("R5", "imm", a.imm, e.imm);
        cmp("R8", "dst", {a.dst, a.dm}, {e.dst, e.dm});
    endtask

    task automatic run(input int busy_pct);
        int cyc = 0;
        bit held = 0;
        exp_t prev;
        while ((bq.size() > 0 || eq.size() > 0) && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            in_valid  = (bq.size() > 0) && ($urandom_range(0, 99) < busy_pct);
            in_data   = in_valid ? bq[0] : 8'h00;
            out_ready = ($urandom_range(0, 99) < busy_pct);
            #1;
            // R1: input stalls only while a record waits
            cmp("R1", "in_ready", 32'(in_ready), 32'(!out_valid || out_ready));
            if (held) begin
                cmp("R1", "held_valid", 32'(out_valid), 32'd1);
                cmp_rec(grab(), prev);
            end
            held = 0;
            if (out_valid && !out_ready) begin
                held = 1;
                prev = grab();
            end
            if (in_valid && in_ready) void'(bq.pop_front());
            if (out_valid && out_ready) begin
                if (eq.size() == 0) cmp("R1", "extra_record", 32'd1, 32'd0);
                else cmp_rec(grab(), eq.pop_front());
            end
        end
        if (bq.size() > 0 || eq.size() > 0) cmp("R1", "watchdog", 32'(eq.size()), 32'd0);
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
    endtask

    task automatic load_set();
        insn(7, 120'h69622f6c642d6c);      // R6 full immediate, disp8
        insn(3, 120'h6BC1F0);              // R6 one-byte immediate sign-extended
        insn(5, 120'h6669C83412);          // R9 prefix gives 16-bit immediate
        insn(5, 120'hB878563412);          // R7 full-width move
        insn(2, 120'hB37F);                // R7 8-bit move
        insn(3, 120'h66B0AA);              // R9 prefix ignored on 8-bit opcode
        insn(4, 120'h66BC1122);            // R9 16-bit move
        insn(2, 120'h01D8);                // R8 reg-reg, r/m is destination
        insn(3, 120'h0345F8);              // R8 reg destination, R3 negative disp8
        insn(1, 120'h8B);                  // R10 unsupported, resync
        insn(7, 120'h31048D00100000);      // R4 SIB base 101 under mod 00
        insn(6, 120'h290578563412);        // R3 disp32 only, memory destination
        insn(4, 120'h28442408);            // R4 SIB with disp8, 8-bit
        insn(7, 120'h3B849100010000);      // R4 SIB with disp32
        insn(7, 120'h69042478563412);      // R6 SIB, no displacement
        insn(5, 120'h6666666666);          // R9 R10 prefix limit reached
        insn(1, 120'h90);                  // R10 single-byte error
        insn(3, 120'h6601C0);              // R9 16-bit ALU
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R12
        cmp("R12", "reset_out_valid", 32'(out_valid), 32'd0);
        cmp("R12", "reset_in_ready", 32'(in_ready), 32'd1);
        rst_n = 1'b1;
        load_set();
        run(60);
        load_set();
        run(100);
        load_set();
        run(30);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule